// File: doc/BRIEF.md
# Pipelined Fixed-Point Complex Multiplier

This block multiplies two complex numbers whose real and imaginary parts are signed fractions of `DW` bits (one sign bit, the remaining bits below the binary point; 8 bits by default). It is meant for twiddle-factor multiplication inside a pipelined FFT datapath. Each of the four real cross products is first reduced back to `DW` bits, by truncation or by round-half-up as chosen for that sample. The reduced products are then subtracted (real part) or added (imaginary part) into results one bit wider than the operands, so the combination step can never overflow.

The block is a two-stage pipeline. The first stage registers the four full-width products. The second stage reduces them, combines them and registers the results. A valid flag runs beside the data. The rounding choice is captured together with the operands, so consecutive samples may use different modes. When no valid sample arrives, the outputs keep their previous values.

Top module: `cmul_fixed`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0 and `re_out` = `im_out` = 0.
- R2: `out_valid` is high exactly two cycles after a cycle in which `in_valid` was high at the clock edge, and low otherwise.
- R3: `re_out` equals Q(a_re·b_re) − Q(a_im·b_im), as a signed `DW+1`-bit integer in the same LSB units as the operands.
- R4: `im_out` equals Q(a_re·b_im) + Q(a_im·b_re), as a signed `DW+1`-bit integer.
- R5: With `rnd_sel` = 0, Q(p) takes bits [2·DW−2 : DW−1] of the full 2·DW-bit two's-complement product p, i.e. floor(p / 2^(DW−1)).
- R6: With `rnd_sel` = 1, Q(p) adds 2^(DW−2) (one half output LSB) to p before taking the same bits, i.e. floor((p + 2^(DW−2)) / 2^(DW−1)).
- R7: A product of the most negative value with itself (−1 × −1) gives Q = 2^(DW−1) − 1 (127 for 8 bits) in either mode, not −1.
- R8: `re_out` and `im_out` always lie within ±2·(2^(DW−1) − 1) (±254 for 8 bits), including for all extreme operands.
- R9: `rnd_sel` is sampled with the operands of the same sample, so mode changes between back-to-back samples affect only their own results.
- R10: A cycle with `in_valid` low leaves `re_out` and `im_out` unchanged, whatever the operand and mode inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| rnd_sel | input | 1 | 0 = truncate products, 1 = round products |
| a_re | input | DW | Real part of operand A, signed fraction |
| a_im | input | DW | Imaginary part of operand A, signed fraction |
| b_re | input | DW | Real part of operand B, signed fraction |
| b_im | input | DW | Imaginary part of operand B, signed fraction |
| out_valid | output | 1 | Results are valid this cycle |
| re_out | output | DW+1 | Real result, signed |
| im_out | output | DW+1 | Imaginary result, signed |

## Verification
Saturation of the −1 × −1 product and the rounding offset can apply in the same cycle. When they do, the half-LSB addition must not pull the corrected value off 127. The bench provokes this by feeding (−1, −1) × (−1, −1) and mixed extreme operands in both modes, back to back with alternating modes. It judges each result against a reference model that applies saturation before any rounding. This also checks that R8's range bound holds at those extremes.

// File: rtl/cmul_pkg.sv
// Shared definitions for the fixed-point complex multiplier.
// Assumes two's-complement fractional operands with the binary point
// directly below the sign bit.
package cmul_pkg;
    // Product reduction mode carried through the pipeline with each sample
    typedef enum logic {
        RED_TRUNC = 1'b0,
        RED_ROUND = 1'b1
    } red_mode_e;

    // Index of each cross product inside the product array
    localparam int unsigned P_RR  = 0;  // a_re * b_re
    localparam int unsigned P_II  = 1;  // a_im * b_im
    localparam int unsigned P_RI  = 2;  // a_re * b_im
    localparam int unsigned P_IR  = 3;  // a_im * b_re
    localparam int unsigned N_PRD = 4;
endpackage

// File: rtl/cmul_mul_stage.sv
// First pipeline stage: forms the four full-width cross products and
// registers them with the valid flag and the reduction mode.
// Assumes operands are stable at the clock edge where in_valid is high;
// product registers load only on valid samples.
module cmul_mul_stage
    import cmul_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  red_mode_e              mode_in,
    input  logic signed [DW-1:0]   a_re,
    input  logic signed [DW-1:0]   a_im,
    input  logic signed [DW-1:0]   b_re,
    input  logic signed [DW-1:0]   b_im,
    output logic                   v_q,
    output red_mode_e              mode_q,
    output logic [N_PRD*2*DW-1:0]  prod_q
);
    localparam int unsigned PW = 2 * DW;

    logic signed [DW-1:0] op_x [N_PRD];
    logic signed [DW-1:0] op_y [N_PRD];

    // Route operands to each multiplier in product-index order
    always_comb begin
        op_x[P_RR] = a_re;  op_y[P_RR] = b_re;
        op_x[P_II] = a_im;  op_y[P_II] = b_im;
        op_x[P_RI] = a_re;  op_y[P_RI] = b_im;
        op_x[P_IR] = a_im;  op_y[P_IR] = b_re;
    end

    genvar g;
    generate
        for (g = 0; g < N_PRD; g++) begin : g_mul
            logic signed [PW-1:0] prod_d;
            // Full-precision signed product, cannot overflow PW bits
            assign prod_d = PW'(op_x[g]) * PW'(op_y[g]);

            // Capture this product on valid samples only
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prod_q[g*PW +: PW] <= '0;
                else if (in_valid)
                    prod_q[g*PW +: PW] <= prod_d;
            end
        end
    endgenerate

    // Carry valid flag every cycle and the mode with the sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            mode_q <= RED_TRUNC;
        end else begin
            v_q <= in_valid;
            if (in_valid)
                mode_q <= mode_in;
        end
    end
endmodule

// File: rtl/cmul_quant.sv
// Combinational reduction of one 2*DW-bit fractional product back to DW
// bits. Truncation keeps bits [2DW-2:DW-1]; rounding adds half an output
// LSB first. The single unrepresentable result (-1 * -1 = +1) is clamped
// to the largest positive value. Assumes the product came from two DW-bit
// signed operands, so the half-LSB addition cannot overflow PW bits.
module cmul_quant
    import cmul_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic signed [2*DW-1:0] prod,
    input  red_mode_e              mode,
    output logic signed [DW-1:0]   q
);
    localparam int unsigned PW = 2 * DW;
    localparam logic [PW-1:0] HALF  = {{(PW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
    localparam logic [PW-1:0] PLUS1 = {2'b01, {(PW-2){1'b0}}};
    localparam logic [DW-1:0] QMAX  = {1'b0, {(DW-1){1'b1}}};

    logic [PW-1:0] biased;
    logic          is_plus1;
    logic          unused_bits;

    // Add the rounding offset when rounding mode is selected
    assign biased      = prod + ((mode == RED_ROUND) ? HALF : '0);
    // Detect the only product that has no DW-bit fractional image
    assign is_plus1    = (prod == PLUS1);
    // Pick the kept field, or clamp the +1 case
    assign q           = is_plus1 ? QMAX : biased[PW-2:DW-1];
    assign unused_bits = ^{biased[PW-1], biased[DW-2:0]};
endmodule

// File: rtl/cmul_fixed.sv
// Two-stage fixed-point complex multiplier (top level).
// Stage 1 registers the four cross products; stage 2 reduces each to DW
// bits, forms re = rr - ii and im = ri + ir in DW+1 bits, and registers
// them. Outputs hold their value between valid samples.
module cmul_fixed
    import cmul_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 rnd_sel,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    output logic                 out_valid,
    output logic signed [DW:0]   re_out,
    output logic signed [DW:0]   im_out
);
    localparam int unsigned PW = 2 * DW;
    localparam int unsigned OW = DW + 1;

    red_mode_e                mode_in;
    logic                     v1;
    red_mode_e                mode1;
    logic [N_PRD*PW-1:0]      prod1;
    logic signed [DW-1:0]     qv [N_PRD];
    logic signed [OW-1:0]     re_d;
    logic signed [OW-1:0]     im_d;

    // Map the select pin onto the mode type
    assign mode_in = rnd_sel ? RED_ROUND : RED_TRUNC;

    cmul_mul_stage #(.DW(DW)) i_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .mode_in  (mode_in),
        .a_re     (a_re),
        .a_im     (a_im),
        .b_re     (b_re),
        .b_im     (b_im),
        .v_q      (v1),
        .mode_q   (mode1),
        .prod_q   (prod1)
    );

    genvar g;
    generate
        for (g = 0; g < N_PRD; g++) begin : g_red
            cmul_quant #(.DW(DW)) i_quant (
                .prod (prod1[g*PW +: PW]),
                .mode (mode1),
                .q    (qv[g])
            );
        end
    endgenerate

    // Combine reduced products with one guard bit so no sum overflows
    always_comb begin
        re_d = OW'(qv[P_RR]) - OW'(qv[P_II]);
        im_d = OW'(qv[P_RI]) + OW'(qv[P_IR]);
    end

    // Output register: valid follows stage 1, data loads on valid only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            re_out    <= '0;
            im_out    <= '0;
        end else begin
            out_valid <= v1;
            if (v1) begin
                re_out <= re_d;
                im_out <= im_d;
            end
        end
    end
endmodule

// File: rtl/cmul_fixed_chk.sv
// Checker for cmul_fixed: reset state, pipeline latency, output hold
// between samples and the output range bound. Uses a small counter of
// cycles since reset so no property looks back past the reset release.
module cmul_fixed_chk #(
    parameter int unsigned DW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic signed [DW:0] re_out,
    input logic signed [DW:0] im_out
);
    localparam int LIM = 2 * ((1 << (DW - 1)) - 1);

    logic [1:0] warm;

    // Count clock edges seen out of reset, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm <= 2'd0;
        else if (warm != 2'd3)
            warm <= warm + 2'd1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && re_out == '0 && im_out == '0));

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd1 && !out_valid) |-> ($stable(re_out) && $stable(im_out)));

    a_r8_re_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(re_out) <= LIM && int'(re_out) >= -LIM));

    a_r8_im_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(im_out) <= LIM && int'(im_out) >= -LIM));
endmodule

bind cmul_fixed cmul_fixed_chk #(.DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .re_out    (re_out),
    .im_out    (im_out)
);

// File: tb/test_cmul_fixed.sv
// Scoreboard bench for cmul_fixed (DW = 8). The driver pushes expected
// results into queues; a monitor pops and compares on each valid output.
module test_cmul_fixed;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              rnd_sel = 1'b0;
    logic signed [7:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic              out_valid;
    logic signed [8:0] re_out, im_out;

    int    n_run = 0;
    int    n_fail = 0;
    int    q_re[$];
    int    q_im[$];
    string q_tag[$];
    int    last_re = 0, last_im = 0;

    cmul_fixed #(.DW(8)) i_cmul_fixed (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rnd_sel(rnd_sel),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .out_valid(out_valid), .re_out(re_out), .im_out(im_out)
    );

    always #5 clk = ~clk;

    // Reference reduction of one product (R5, R6, R7)
    function automatic int qref(int p, bit rnd);
        int t;
        if (p == 16384) return 127;
        t = p + (rnd ? 64 : 0);
        return t >>> 7;
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Driver: present one sample for one cycle and queue its expectation
    task automatic send(int ar, int ai, int br, int bi, bit rnd, string tag);
        q_re.push_back(qref(ar*br, rnd) - qref(ai*bi, rnd));
        q_im.push_back(qref(ar*bi, rnd) + qref(ai*br, rnd));
        q_tag.push_back(tag);
        a_re = 8'(ar); a_im = 8'(ai); b_re = 8'(br); b_im = 8'(bi);
        rnd_sel = rnd; in_valid = 1'b1;
        @(negedge clk);
    endtask

    // Idle cycles with junk on the data pins (R10)
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            a_re = 8'($urandom); a_im = 8'($urandom);
            b_re = 8'($urandom); b_im = 8'($urandom);
            rnd_sel = 1'($urandom);
            @(negedge clk);
        end
    endtask

    // Monitor: compare valid results, check hold on idle cycles
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (q_re.size() == 0) begin
                    check("R2 unexpected out_valid", 1, 0);
                end else begin
                    string t;
                    int er, ei;
                    t = q_tag.pop_front();
                    er = q_re.pop_front();
                    ei = q_im.pop_front();
                    check({"R3 re ", t}, int'(re_out), er);
                    check({"R4 im ", t}, int'(im_out), ei);
                end
                last_re = int'(re_out);
                last_im = int'(im_out);
            end else begin
                check("R10 re hold", int'(re_out), last_re);
                check("R10 im hold", int'(im_out), last_im);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 re_out", int'(re_out), 0);
        check("R1 im_out", int'(im_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: latency of exactly two edges
        send(64, 0, 3, 0, 1'b0, "R2 latency");
        check("R2 not yet valid", int'(out_valid), 0);
        idle(1);
        check("R2 valid after two", int'(out_valid), 1);
        idle(3);

        // R5 / R6: half-LSB products, positive and negative, both modes
        send(64, 0, 3, 0, 1'b0, "R5 trunc +1.5");     // re 1
        send(64, 0, 3, 0, 1'b1, "R6 round +1.5");     // re 2
        send(-64, 0, 3, 0, 1'b0, "R5 trunc -1.5");    // re -2
        send(-64, 0, 3, 0, 1'b1, "R6 round -1.5");    // re -1
        send(0, 64, 0, 3, 1'b1, "R6 round in ii");
        send(64, 64, 3, 3, 1'b0, "R4 trunc sum");
        idle(3);

        // R7 / R8: saturation and extreme operands, both modes back to back (R9)
        send(-128, 0, -128, 0, 1'b0, "R7 sat trunc");
        send(-128, 0, -128, 0, 1'b1, "R7 sat round");
        send(-128, -128, -128, -128, 1'b1, "R8 all -1");
        send(-128, 127, -128, -128, 1'b0, "R8 re max");
        send(127, -128, -128, 127, 1'b1, "R8 mixed");
        send(-128, -128, 127, 127, 1'b0, "R8 im min");
        idle(2);

        // R9: alternating modes with random data and random bubbles
        for (int i = 0; i < 300; i++) begin
            send($signed(8'($urandom)), $signed(8'($urandom)),
                 $signed(8'($urandom)), $signed(8'($urandom)),
                 1'(i), "R9 random");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end

        idle(4);
        check("R2 all results seen", q_re.size(), 0);
        finish_run();
    end
endmodule